// File: doc/BRIEF.md
# Sixteen-bit Tick Timer with Clear-on-Compare

This block is a 16-bit synchronous up-counter. It advances only on system clock cycles where an external prescaler asserts a tick enable. It has two modes, chosen by a mode input.

- **Free-running mode.** The counter runs up to all ones and rolls over to zero. A shared 16-bit register latches the running count when the selected edge arrives on a synchronized capture input.
- **Clear-on-compare mode.** The same shared register holds TOP. The counter returns to zero on the tick after it equals TOP, so TOP sets the period.

Software reaches the count, the TOP/capture register and two sticky flags through a small register bus:

- Address 0 is the count.
- Address 1 is the TOP/capture register.
- Address 2 holds the flags: bit 0 is overflow and bit 1 is capture/TOP.

Writing a one to a flag bit clears that flag. Writes to TOP take effect at once, with no shadow copy. If software lowers TOP below the running count, the compare is missed, and the counter completes a full roll-over before it can match again.

Top module: `tick_timer16`

## Requirements
- R1: When `tick_en` is low and the count is not being written, the count holds its value.
- R2: In free-running mode (`ctc_mode`=0), each tick adds one to the count, and 0xFFFF rolls over to 0x0000.
- R3: The overflow flag (flag bit 0) is set by any tick that moves the count from 0xFFFF to 0x0000, in either mode, including clear-on-compare with TOP = 0xFFFF.
- R4: In clear-on-compare mode (`ctc_mode`=1), a tick loads zero when the count equals TOP and otherwise adds one.
- R5: In clear-on-compare mode, the capture/TOP flag (flag bit 1) is set by every tick that finds the count equal to TOP.
- R6: A write to TOP is used for the very next compare. If the count is already above the new TOP, no match occurs until the count has rolled over through 0x0000.
- R7: In free-running mode, a selected edge on `cap_in` copies the count into the TOP/capture register and sets flag bit 1. The copy happens at the third rising clock edge after `cap_in` changes, using the count held before that edge.
- R8: With `cap_fall`=0 only rising edges of `cap_in` capture. With `cap_fall`=1 only falling edges capture. The other edge has no effect.
- R9: In clear-on-compare mode, capture events neither change the TOP/capture register nor set flag bit 1.
- R10: Writing address 2 clears each flag whose data bit is one and leaves flags whose bit is zero. A set condition in the same cycle as a clear leaves the flag set.
- R11: A bus write to address 0 or address 1 takes priority over the tick, compare-clear or capture update of that register in the same cycle. `bus_rdata` shows the addressed register combinationally, with flags at bits 1:0 of address 2.
- R12: After reset the count is 0x0000, the TOP/capture register is 0xFFFF and both flags are clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Timer clock enable from the prescaler |
| ctc_mode | input | 1 | 1 = clear-on-compare, 0 = free-running |
| cap_fall | input | 1 | Capture edge select: 1 = falling, 0 = rising |
| cap_in | input | 1 | Asynchronous capture input |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| ovf_flag | output | 1 | Sticky overflow flag |
| top_flag | output | 1 | Sticky capture/TOP flag |

## Verification
Two functions can land on the same clock edge in this block:

- a software flag clear and a hardware flag set;
- a software count write and a tick.

The bench provokes the first by parking the count at 0xFFFF and then asserting `tick_en` in the cycle where it writes ones to the flag register. It judges the result by reading the overflow flag, which must still be one. It provokes the second by writing a count value in a cycle with `tick_en` high, and requires the written value to appear unchanged. A table of mode, TOP, start and tick-count vectors covers roll-over, early TOP, TOP at both extremes and a missed match.

// File: rtl/timer_pkg.sv
package timer_pkg;
   localparam int unsigned ADDR_W = 2;
   localparam int unsigned FLAG_N = 2;

   typedef enum logic [ADDR_W-1:0] {
      SEL_COUNT  = 2'd0,
      SEL_TOPCAP = 2'd1,
      SEL_FLAGS  = 2'd2
   } reg_sel_e;

   localparam int unsigned FLG_OVF = 0;
   localparam int unsigned FLG_TOP = 1;
endpackage

// File: rtl/cap_edge_sync.sv
module cap_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   input  logic fall_sel,
   output logic edge_hit
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cap_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-1:0], async_in};
   end

   // chain_q[STAGES-1] is the synchronized level, chain_q[STAGES] its delayed copy
   logic now_lvl, old_lvl;
   assign now_lvl = chain_q[STAGES-1];
   assign old_lvl = chain_q[STAGES];

   always_comb begin
      if (fall_sel) edge_hit = !now_lvl && old_lvl;
      else          edge_hit = now_lvl && !old_lvl;
   end
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
   parameter int unsigned WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             ctc_mode,
   input  logic [WIDTH-1:0] top_val,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   output logic [WIDTH-1:0] count,
   output logic             ovf_set,
   output logic             match_set
);
   localparam logic [WIDTH-1:0] CNT_MAX = {WIDTH{1'b1}};

   if (WIDTH < 2) begin : g_bad_width
      $error("tmr_count_core: WIDTH must be at least 2");
   end

   logic             at_max, at_top, do_clear;
   logic [WIDTH-1:0] cnt_d;

   always_comb begin
      at_max   = (count == CNT_MAX);
      at_top   = (count == top_val);
      do_clear = ctc_mode && at_top;
      cnt_d    = count;
      if (wr_en)         cnt_d = wr_data;
      else if (tick)     cnt_d = do_clear ? '0 : count + 1'b1;
      ovf_set   = tick && !wr_en && at_max;
      match_set = tick && !wr_en && do_clear;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count <= '0;
      else        count <= cnt_d;
   end

   a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !wr_en) |=> $stable(count));
   a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wr_en && !ctc_mode && count == CNT_MAX) |=> (count == '0));
   a_r4_ctc_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wr_en && ctc_mode && count == top_val) |=> (count == '0));
   a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (count == $past(wr_data)));
endmodule

// File: rtl/w1c_flag.sv
module w1c_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 1'b0;
      else if (set) q <= 1'b1;
      else if (clr) q <= 1'b0;
   end

   a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> q);
   a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set) |=> !q);
endmodule

// File: rtl/tick_timer16.sv
module tick_timer16
   import timer_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              ctc_mode,
   input  logic              cap_fall,
   input  logic              cap_in,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [CNT_W-1:0]  bus_wdata,
   output logic [CNT_W-1:0]  bus_rdata,
   output logic              ovf_flag,
   output logic              top_flag
);
   if (CNT_W < FLAG_N) begin : g_bad_cnt_w
      $error("tick_timer16: CNT_W must cover the flag bits");
   end

   logic [CNT_W-1:0]  count, topcap_q;
   logic              cnt_we, reg_we, flg_we;
   logic              cap_edge, cap_take;
   logic              ovf_set, match_set;
   logic [FLAG_N-1:0] flg_set, flg_clr, flg_q;

   assign cnt_we = bus_we && (bus_addr == SEL_COUNT);
   assign reg_we = bus_we && (bus_addr == SEL_TOPCAP);
   assign flg_we = bus_we && (bus_addr == SEL_FLAGS);

   cap_edge_sync #(.STAGES(SYNC_STAGES)) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_in(cap_in),
      .fall_sel(cap_fall),
      .edge_hit(cap_edge)
   );

   assign cap_take = cap_edge && !ctc_mode;

   tmr_count_core #(.WIDTH(CNT_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick_en),
      .ctc_mode (ctc_mode),
      .top_val  (topcap_q),
      .wr_en    (cnt_we),
      .wr_data  (bus_wdata),
      .count    (count),
      .ovf_set  (ovf_set),
      .match_set(match_set)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        topcap_q <= {CNT_W{1'b1}};
      else if (reg_we)   topcap_q <= bus_wdata;
      else if (cap_take) topcap_q <= count;
   end

   always_comb begin
      flg_set          = '0;
      flg_set[FLG_OVF] = ovf_set;
      flg_set[FLG_TOP] = match_set || cap_take;
      flg_clr          = flg_we ? bus_wdata[FLAG_N-1:0] : '0;
   end

   for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
      w1c_flag u_flag (
         .clk  (clk),
         .rst_n(rst_n),
         .set  (flg_set[g]),
         .clr  (flg_clr[g]),
         .q    (flg_q[g])
      );
   end

   assign ovf_flag = flg_q[FLG_OVF];
   assign top_flag = flg_q[FLG_TOP];

   always_comb begin
      unique case (bus_addr)
         SEL_COUNT:  bus_rdata = count;
         SEL_TOPCAP: bus_rdata = topcap_q;
         SEL_FLAGS:  bus_rdata = {{(CNT_W-FLAG_N){1'b0}}, flg_q};
         default:    bus_rdata = '0;
      endcase
   end

   a_r9_ctc_keeps_top: assert property (@(posedge clk) disable iff (!rst_n)
      (ctc_mode && !reg_we) |=> $stable(topcap_q));
   a_r7_capture_copy: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_take && !reg_we) |=> (topcap_q == $past(count) && top_flag));
   a_r3_ovf_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && !cnt_we && count == {CNT_W{1'b1}}) |=> (ovf_flag && count == '0));
endmodule

// File: tb/test_tick_timer16.sv
`timescale 1ns/1ps
module test_tick_timer16;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0, ctc_mode = 1'b0, cap_fall = 1'b0, cap_in = 1'b0;
   logic        bus_we = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [15:0] bus_wdata = 16'd0;
   logic [15:0] bus_rdata;
   logic        ovf_flag, top_flag;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   tick_timer16 i_tick_timer16 (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ctc_mode(ctc_mode),
      .cap_fall(cap_fall), .cap_in(cap_in), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ovf_flag(ovf_flag), .top_flag(top_flag)
   );

   typedef struct packed {
      logic        mode;
      logic [15:0] top;
      logic [15:0] start;
      logic [7:0]  ticks;
      logic [15:0] exp_cnt;
      logic        exp_ovf;
      logic        exp_tf;
   } vec_t;

   localparam vec_t VEC [0:7] = '{
      '{1'b0, 16'h0100, 16'h0010, 8'd5, 16'h0015, 1'b0, 1'b0},  // R2 plain count
      '{1'b0, 16'h0100, 16'hFFFE, 8'd3, 16'h0001, 1'b1, 1'b0},  // R2 R3 roll-over
      '{1'b1, 16'h0005, 16'h0000, 8'd5, 16'h0005, 1'b0, 1'b0},  // R4 reaches TOP
      '{1'b1, 16'h0005, 16'h0000, 8'd8, 16'h0002, 1'b0, 1'b1},  // R4 R5 clears
      '{1'b1, 16'h0003, 16'h000A, 8'd4, 16'h000E, 1'b0, 1'b0},  // R6 missed match
      '{1'b1, 16'h0003, 16'hFFFE, 8'd6, 16'h0000, 1'b1, 1'b1},  // R6 match after wrap
      '{1'b1, 16'hFFFF, 16'hFFFE, 8'd2, 16'h0000, 1'b1, 1'b1},  // R3 TOP at max
      '{1'b1, 16'h0000, 16'h0000, 8'd3, 16'h0000, 1'b0, 1'b1}   // R4 TOP zero
   };

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic run_ticks(input int n);
      @(negedge clk);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [15:0] d;
      repeat (3) @(negedge clk);
      // R12 reset state
      rd(2'd0, d); check("R12 count", d, 16'h0000);
      rd(2'd1, d); check("R12 topcap", d, 16'hFFFF);
      rd(2'd2, d); check("R12 flags", d, 16'h0000);
      rst_n = 1'b1;

      for (int i = 0; i < 8; i++) begin
         ctc_mode = VEC[i].mode;
         wr(2'd1, VEC[i].top);
         wr(2'd0, VEC[i].start);
         wr(2'd2, 16'h0003);
         run_ticks(int'(VEC[i].ticks));
         rd(2'd0, d); check($sformatf("R2/R4/R6 vec%0d count", i), d, VEC[i].exp_cnt);
         check($sformatf("R3 vec%0d ovf", i), {15'd0, ovf_flag}, {15'd0, VEC[i].exp_ovf});
         check($sformatf("R5 vec%0d topflag", i), {15'd0, top_flag}, {15'd0, VEC[i].exp_tf});
      end

      // R1 no tick, count holds
      ctc_mode = 1'b0;
      wr(2'd0, 16'h0777);
      repeat (5) @(negedge clk);
      rd(2'd0, d); check("R1 hold", d, 16'h0777);

      // R7 rising-edge capture in free-running mode
      wr(2'd0, 16'h1234);
      wr(2'd2, 16'h0003);
      cap_in = 1'b1;
      repeat (4) @(negedge clk);
      rd(2'd1, d); check("R7 captured count", d, 16'h1234);
      check("R7 flag", {15'd0, top_flag}, 16'h0001);

      // R8 falling edge ignored while rising selected
      wr(2'd2, 16'h0003);
      wr(2'd0, 16'h0055);
      cap_in = 1'b0;
      repeat (4) @(negedge clk);
      rd(2'd1, d); check("R8 fall ignored", d, 16'h1234);
      check("R8 no flag", {15'd0, top_flag}, 16'h0000);

      // R8 falling selected: rising ignored, falling captures
      cap_fall = 1'b1;
      repeat (2) @(negedge clk);
      cap_in = 1'b1;
      repeat (4) @(negedge clk);
      rd(2'd1, d); check("R8 rise ignored", d, 16'h1234);
      wr(2'd0, 16'h0042);
      cap_in = 1'b0;
      repeat (4) @(negedge clk);
      rd(2'd1, d); check("R8 fall captured", d, 16'h0042);

      // R9 capture ignored in clear-on-compare mode
      ctc_mode = 1'b1;
      wr(2'd1, 16'h0200);
      wr(2'd2, 16'h0003);
      cap_in = 1'b1;
      repeat (3) @(negedge clk);
      cap_in = 1'b0;
      repeat (4) @(negedge clk);
      rd(2'd1, d); check("R9 top kept", d, 16'h0200);
      check("R9 no flag", {15'd0, top_flag}, 16'h0000);

      // R10 selective clear: both flags set, clear bit 0 only
      ctc_mode = 1'b0;
      cap_fall = 1'b0;
      wr(2'd0, 16'hFFFF);
      run_ticks(1);
      cap_in = 1'b1;
      repeat (4) @(negedge clk);
      wr(2'd2, 16'h0001);
      rd(2'd2, d); check("R10 clear ovf only", d, 16'h0002);

      // R10 set wins over clear in the same cycle
      wr(2'd0, 16'hFFFF);
      @(negedge clk);
      tick_en = 1'b1; bus_we = 1'b1; bus_addr = 2'd2; bus_wdata = 16'h0001;
      @(negedge clk);
      tick_en = 1'b0; bus_we = 1'b0;
      check("R10 set wins", {15'd0, ovf_flag}, 16'h0001);

      // R11 count write beats tick in the same cycle
      @(negedge clk);
      tick_en = 1'b1; bus_we = 1'b1; bus_addr = 2'd0; bus_wdata = 16'h0100;
      @(negedge clk);
      tick_en = 1'b0; bus_we = 1'b0;
      rd(2'd0, d); check("R11 write wins", d, 16'h0100);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule